// File: doc/BRIEF.md
# Memory-Mapped Access Router

This block sits on the data port of a processor core and steers every load and store to one of two targets: a peripheral window (for example a display controller with its registers and pixel buffer) or the general external memory path. The target is picked from the most significant bits of the access address. Address, write data and byte strobes go to both targets at all times. Only the chosen target receives a write enable. The read data returned to the core passes through a multiplexer that follows the same selection.

The router is purely combinational and adds no cycles. Read data reaches the core on whatever schedule the chosen target keeps. The selection code is also exported, so that surrounding logic can see which region an access falls into. The address width, the data width, the width of the selection field and the code that selects the peripheral are all parameters. The defaults are a 32-bit address, 32-bit data, a 3-bit field and code 1.

Top module: `mmio_router`

## Requirements
- R1: `devSel` equals the top `SEL_W` bits of `cpuAddr` (bits 31 down to 29 by default) in the same cycle.
- R2: `periphAddr`, `periphWdata` and `periphStrb` equal `cpuAddr`, `cpuWdata` and `cpuStrb` whatever the selection code is.
- R3: `extAddr`, `extWdata` and `extStrb` equal `cpuAddr`, `cpuWdata` and `cpuStrb` whatever the selection code is.
- R4: `periphWe` equals `cpuWe` when the selection code equals `PERIPH_ID` (default 1), and is 0 for every other code.
- R5: `extWe` equals `cpuWe` when the selection code differs from `PERIPH_ID`, and is 0 when it matches.
- R6: When the selection code equals `PERIPH_ID`, `cpuRdata` equals `periphRdata`, and a change on `extRdata` has no effect on it.
- R7: When the selection code differs from `PERIPH_ID`, `cpuRdata` equals `extRdata`, and a change on `periphRdata` has no effect on it.
- R8: Every output settles from the current inputs with no clock edge in between; the block holds no state.
- R9: At most one of `periphWe` and `extWe` is high. Both are 0 when `cpuWe` is 0. When `cpuWe` is 1, exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuAddr | input | 32 | Access address from the core |
| cpuWdata | input | 32 | Store data from the core |
| cpuStrb | input | 4 | Byte-lane strobes from the core |
| cpuWe | input | 1 | Store request from the core |
| cpuRdata | output | 32 | Load data returned to the core |
| devSel | output | 3 | Decoded selection code |
| periphAddr | output | 32 | Address to the peripheral window |
| periphWdata | output | 32 | Store data to the peripheral window |
| periphStrb | output | 4 | Byte strobes to the peripheral window |
| periphWe | output | 1 | Gated store enable to the peripheral window |
| periphRdata | input | 32 | Load data from the peripheral window |
| extAddr | output | 32 | Address to the external port |
| extWdata | output | 32 | Store data to the external port |
| extStrb | output | 4 | Byte strobes to the external port |
| extWe | output | 1 | Gated store enable to the external port |
| extRdata | input | 32 | Load data from the external port |

## Verification
The assertions are evaluated whenever the inputs change. They assume that the address and the store request are known (not X or Z) and skip the checks until then. The bench therefore drives every input to a defined value before it makes its first comparison. It covers all eight selection codes in a directed sweep. It then draws fully random addresses, data, strobes and store requests, so both known and arbitrary values reach every field.

// File: rtl/mmio_router_pkg.sv
package mmio_router_pkg;

  // Routing strobes handed from the decoder to the datapath.
  typedef struct packed {
    logic periphHit;   // access falls in the peripheral window
    logic extHit;      // access falls anywhere else
  } routeStrobe_t;

  // Read-return multiplexer implementation choice.
  typedef enum logic [0:0] {
    MUX_TERNARY = 1'b0,
    MUX_ANDOR   = 1'b1
  } muxStyle_e;

endpackage

// File: rtl/mmio_route_ctrl.sv
module mmio_route_ctrl
  import mmio_router_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SEL_W    = 3,
  parameter int PERIPH_ID = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEL_W-1:0]  sel,
  output routeStrobe_t      route
);

  localparam int SEL_LSB = ADDR_W - SEL_W;
  localparam logic [SEL_W-1:0] PERIPH_CODE = SEL_W'(PERIPH_ID);

  logic [SEL_W-1:0] selField;
  logic             hit;

  assign selField = addr[ADDR_W-1:SEL_LSB];
  assign hit      = (selField == PERIPH_CODE);

  always_comb begin
    sel             = selField;
    route.periphHit = hit;
    route.extHit    = ~hit;
  end

endmodule

// File: rtl/mmio_route_dp.sv
module mmio_route_dp
  import mmio_router_pkg::*;
#(
  parameter int        ADDR_W    = 32,
  parameter int        DATA_W    = 32,
  parameter muxStyle_e MUX_STYLE = MUX_ANDOR
) (
  input  routeStrobe_t          route,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuWdata,
  input  logic [DATA_W/8-1:0]   cpuStrb,
  input  logic                  cpuWe,
  output logic [DATA_W-1:0]     cpuRdata,
  output logic [ADDR_W-1:0]     periphAddr,
  output logic [DATA_W-1:0]     periphWdata,
  output logic [DATA_W/8-1:0]   periphStrb,
  output logic                  periphWe,
  input  logic [DATA_W-1:0]     periphRdata,
  output logic [ADDR_W-1:0]     extAddr,
  output logic [DATA_W-1:0]     extWdata,
  output logic [DATA_W/8-1:0]   extStrb,
  output logic                  extWe,
  input  logic [DATA_W-1:0]     extRdata
);

  // Request fields fan out to both targets untouched.
  assign periphAddr  = cpuAddr;
  assign periphWdata = cpuWdata;
  assign periphStrb  = cpuStrb;
  assign extAddr     = cpuAddr;
  assign extWdata    = cpuWdata;
  assign extStrb     = cpuStrb;

  // Only the selected target sees the store request.
  assign periphWe = cpuWe & route.periphHit;
  assign extWe    = cpuWe & route.extHit;

  generate
    if (MUX_STYLE == MUX_ANDOR) begin : g_andor
      assign cpuRdata = ({DATA_W{route.periphHit}} & periphRdata)
                      | ({DATA_W{route.extHit}}    & extRdata);
    end else begin : g_ternary
      assign cpuRdata = route.periphHit ? periphRdata : extRdata;
    end
  endgenerate

endmodule

// File: rtl/mmio_router.sv
module mmio_router
  import mmio_router_pkg::*;
#(
  parameter int        ADDR_W    = 32,
  parameter int        DATA_W    = 32,
  parameter int        SEL_W     = 3,
  parameter int        PERIPH_ID = 1,
  parameter muxStyle_e MUX_STYLE = MUX_ANDOR
) (
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W-1:0]   cpuWdata,
  input  logic [DATA_W/8-1:0] cpuStrb,
  input  logic                cpuWe,
  output logic [DATA_W-1:0]   cpuRdata,
  output logic [SEL_W-1:0]    devSel,
  output logic [ADDR_W-1:0]   periphAddr,
  output logic [DATA_W-1:0]   periphWdata,
  output logic [DATA_W/8-1:0] periphStrb,
  output logic                periphWe,
  input  logic [DATA_W-1:0]   periphRdata,
  output logic [ADDR_W-1:0]   extAddr,
  output logic [DATA_W-1:0]   extWdata,
  output logic [DATA_W/8-1:0] extStrb,
  output logic                extWe,
  input  logic [DATA_W-1:0]   extRdata
);

  routeStrobe_t route;

  mmio_route_ctrl #(
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .PERIPH_ID(PERIPH_ID)
  ) u_ctrl (
    .addr (cpuAddr),
    .sel  (devSel),
    .route(route)
  );

  mmio_route_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MUX_STYLE(MUX_STYLE)
  ) u_dp (
    .route      (route),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .cpuStrb    (cpuStrb),
    .cpuWe      (cpuWe),
    .cpuRdata   (cpuRdata),
    .periphAddr (periphAddr),
    .periphWdata(periphWdata),
    .periphStrb (periphStrb),
    .periphWe   (periphWe),
    .periphRdata(periphRdata),
    .extAddr    (extAddr),
    .extWdata   (extWdata),
    .extStrb    (extStrb),
    .extWe      (extWe),
    .extRdata   (extRdata)
  );

endmodule

// File: rtl/mmio_router_chk.sv
module mmio_router_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SEL_W     = 3,
  parameter int PERIPH_ID = 1
) (
  input logic [ADDR_W-1:0]   cpuAddr,
  input logic [DATA_W-1:0]   cpuWdata,
  input logic [DATA_W/8-1:0] cpuStrb,
  input logic                cpuWe,
  input logic [DATA_W-1:0]   cpuRdata,
  input logic [SEL_W-1:0]    devSel,
  input logic [ADDR_W-1:0]   periphAddr,
  input logic [DATA_W-1:0]   periphWdata,
  input logic [DATA_W/8-1:0] periphStrb,
  input logic                periphWe,
  input logic [DATA_W-1:0]   periphRdata,
  input logic [ADDR_W-1:0]   extAddr,
  input logic [DATA_W-1:0]   extWdata,
  input logic [DATA_W/8-1:0] extStrb,
  input logic                extWe,
  input logic [DATA_W-1:0]   extRdata
);

  localparam logic [SEL_W-1:0] PCODE = SEL_W'(PERIPH_ID);

  always_comb begin
    if (!$isunknown({cpuAddr, cpuWe})) begin
      AST_SEL_TOP_BITS: assert (devSel == cpuAddr[ADDR_W-1 -: SEL_W]); // R1
      AST_PERIPH_BCAST: assert (periphAddr == cpuAddr && periphWdata == cpuWdata && periphStrb == cpuStrb); // R2
      AST_EXT_BCAST: assert (extAddr == cpuAddr && extWdata == cpuWdata && extStrb == cpuStrb); // R3
      AST_PERIPH_WE_GATE: assert (!periphWe || (devSel == PCODE && cpuWe)); // R4
      AST_EXT_WE_GATE: assert (!extWe || (devSel != PCODE && cpuWe)); // R5
      AST_SINGLE_WRITER: assert ($countones({periphWe, extWe}) == (cpuWe ? 1 : 0)); // R9
      if (!$isunknown({periphRdata, extRdata})) begin
        AST_RD_PERIPH: assert (devSel != PCODE || cpuRdata == periphRdata); // R6
        AST_RD_EXT: assert (devSel == PCODE || cpuRdata == extRdata); // R7
      end
    end
  end

endmodule

bind mmio_router mmio_router_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .SEL_W    (SEL_W),
  .PERIPH_ID(PERIPH_ID)
) u_chk (
  .cpuAddr    (cpuAddr),
  .cpuWdata   (cpuWdata),
  .cpuStrb    (cpuStrb),
  .cpuWe      (cpuWe),
  .cpuRdata   (cpuRdata),
  .devSel     (devSel),
  .periphAddr (periphAddr),
  .periphWdata(periphWdata),
  .periphStrb (periphStrb),
  .periphWe   (periphWe),
  .periphRdata(periphRdata),
  .extAddr    (extAddr),
  .extWdata   (extWdata),
  .extStrb    (extStrb),
  .extWe      (extWe),
  .extRdata   (extRdata)
);

// File: tb/mmio_router_bench.sv
module mmio_router_bench;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = 3;
  localparam int PID = 1;
  localparam int MAX_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [AW-1:0]   cpuAddr = '0;
  logic [DW-1:0]   cpuWdata = '0;
  logic [DW/8-1:0] cpuStrb = '0;
  logic            cpuWe = 1'b0;
  logic [DW-1:0]   periphRdata = '0;
  logic [DW-1:0]   extRdata = '0;
  logic [DW-1:0]   cpuRdata;
  logic [SW-1:0]   devSel;
  logic [AW-1:0]   periphAddr, extAddr;
  logic [DW-1:0]   periphWdata, extWdata;
  logic [DW/8-1:0] periphStrb, extStrb;
  logic            periphWe, extWe;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  mmio_router u_mmio_router (
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuStrb(cpuStrb), .cpuWe(cpuWe),
    .cpuRdata(cpuRdata), .devSel(devSel),
    .periphAddr(periphAddr), .periphWdata(periphWdata), .periphStrb(periphStrb),
    .periphWe(periphWe), .periphRdata(periphRdata),
    .extAddr(extAddr), .extWdata(extWdata), .extStrb(extStrb),
    .extWe(extWe), .extRdata(extRdata)
  );

  function automatic logic [SW-1:0] expSel(input logic [AW-1:0] a);
    return a[AW-1 -: SW];
  endfunction
  function automatic logic expPeriphWe(input logic [AW-1:0] a, input logic we);
    return we && (expSel(a) == SW'(PID));
  endfunction
  function automatic logic expExtWe(input logic [AW-1:0] a, input logic we);
    return we && (expSel(a) != SW'(PID));
  endfunction
  function automatic logic [DW-1:0] expRdata(input logic [AW-1:0] a,
                                             input logic [DW-1:0] pr,
                                             input logic [DW-1:0] er);
    return (expSel(a) == SW'(PID)) ? pr : er;
  endfunction

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (addr %h)", req, act, exp, cpuAddr);
    end
  endtask

  // Drive just after a falling edge, compare 1 ns later, well before the next rising edge.
  task automatic apply(input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input logic [DW/8-1:0] st, input logic we,
                       input logic [DW-1:0] pr, input logic [DW-1:0] er);
    @(negedge clk);
    cpuAddr = a; cpuWdata = wd; cpuStrb = st; cpuWe = we;
    periphRdata = pr; extRdata = er;
    #1;
    cmp("R1", 64'(devSel), 64'(expSel(a)));
    cmp("R2", 64'(periphAddr ^ a) | 64'(periphWdata ^ wd) | 64'(periphStrb ^ st), 64'd0);
    cmp("R3", 64'(extAddr ^ a) | 64'(extWdata ^ wd) | 64'(extStrb ^ st), 64'd0);
    cmp("R4", 64'(periphWe), 64'(expPeriphWe(a, we)));
    cmp("R5", 64'(extWe), 64'(expExtWe(a, we)));
    cmp((expSel(a) == SW'(PID)) ? "R6" : "R7", 64'(cpuRdata), 64'(expRdata(a, pr, er)));
    cmp("R9", 64'(periphWe & extWe), 64'd0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > MAX_CYCLES) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Idle state: no store request, so neither target may be written (R9).
    @(negedge clk); #1;
    cmp("R9", 64'({periphWe, extWe}), 64'd0);
    cmp("R7", 64'(cpuRdata), 64'(extRdata));

    // Directed sweep of all eight selection codes, store and load.
    for (int s = 0; s < 8; s++) begin
      apply({3'(s), 29'h0ABC_123}, 32'hDEAD_0000 | 32'(s), 4'hF, 1'b1,
            32'h1111_0000 | 32'(s), 32'h2222_0000 | 32'(s));
      apply({3'(s), 29'h1FFF_FFFF}, 32'h0, 4'h3, 1'b0, 32'hAAAA_AAAA, 32'h5555_5555);
    end

    // Boundary addresses around the peripheral window.
    apply(32'h1FFF_FFFF, 32'h1, 4'h1, 1'b1, 32'h10, 32'h20);   // last ext before window
    apply(32'h2000_0000, 32'h2, 4'h2, 1'b1, 32'h30, 32'h40);   // first in window
    apply(32'h3FFF_FFFF, 32'h3, 4'h4, 1'b1, 32'h50, 32'h60);   // last in window
    apply(32'h4000_0000, 32'h4, 4'h8, 1'b1, 32'h70, 32'h80);   // first after window

    // R6/R8: in-window, changing the unselected side has no effect; the selected side follows at once.
    apply(32'h2000_0040, 32'h0, 4'h0, 1'b0, 32'hCAFE_F00D, 32'h0000_0001);
    @(negedge clk); extRdata = 32'hFFFF_FFFF; #1;
    cmp("R6", 64'(cpuRdata), 64'h0000_0000_CAFE_F00D);
    periphRdata = 32'h1234_5678; #0.5;
    cmp("R8", 64'(cpuRdata), 64'h0000_0000_1234_5678);

    // R7/R8: out of window, peripheral data is ignored; selection change is seen immediately.
    apply(32'h8000_0000, 32'h0, 4'h0, 1'b0, 32'h0BAD_BAD0, 32'h0C0F_FEE0);
    @(negedge clk); periphRdata = 32'h7777_7777; #1;
    cmp("R7", 64'(cpuRdata), 64'h0000_0000_0C0F_FEE0);
    cpuAddr = 32'h2000_0000; cpuWe = 1'b1; #0.5;
    cmp("R8", 64'(cpuRdata), 64'h0000_0000_7777_7777);
    cmp("R8", 64'({periphWe, extWe}), 64'd2);

    // Random stimulus.
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = $urandom();
      if (i % 4 == 0) a[AW-1 -: SW] = SW'(PID);   // keep the window well covered
      apply(a, $urandom(), 4'($urandom()), 1'($urandom()), $urandom(), $urandom());
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule